// File: doc/BRIEF.md
# Sequential / Nested Interrupt Controller

This block collects interrupt requests from a parameterised set of lines and offers them to a processor one at a time. The processor sees a valid flag and the vector number of the offered line. It takes an offered interrupt by pulsing an acknowledge, and it signals the end of a handler by pulsing an end-of-handler strobe. A run-time mode input picks between two service policies. In sequential mode, one handler runs at a time and waiting requests are offered in the order they arrived. In nested mode, a more urgent request can cut into a running handler. Line 0 is the most urgent, and urgency falls as the index rises.

Lines that are waiting are kept in an arrival queue. Every acknowledged line is pushed onto an in-service stack, so an interrupted handler is resumed when the handler that preempted it ends. The top of that stack is shown on the outputs as the handler now running. A request is sampled on a rising clock edge. It is dropped when its line is already waiting or already in service.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `irq_valid` and `svc_busy` are 0 and no line is waiting.
- R2: In sequential mode (`nest_mode`=0), `irq_valid` stays 0 while `svc_busy` is 1, even when lines are waiting.
- R3: In sequential mode, waiting lines are offered in order of the clock edge on which they were sampled. Lines sampled on the same edge are offered in ascending index order.
- R4: In nested mode (`nest_mode`=1), the offered vector is the lowest-index waiting line. It is offered when nothing is in service, or when its index is strictly below `svc_vec`.
- R5: In nested mode, a waiting line whose index is equal to or above `svc_vec` is not offered while that handler is in service. It is offered once the handler's end-of-handler arrives.
- R6: `irq_ack` while `irq_valid`=1 takes the offered line out of the waiting set. From the next cycle it is the in-service top: `svc_busy`=1 and `svc_vec` equals that vector. `irq_ack` while `irq_valid`=0 is ignored.
- R7: `irq_eoi` pops the top in-service entry, and the next cycle shows the entry below it (or `svc_busy`=0 if none). `irq_eoi` with nothing in service is ignored. When `irq_ack` and `irq_eoi` fall in the same cycle, the pop takes place before the push.
- R8: A request on a line that is already waiting, or in service, is not queued a second time. This also holds on the edge that ends that line's handler.
- R9: A request sampled at a clock edge makes the line waiting right after that edge, so it can be offered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| nest_mode | input | 1 | 0 = sequential service, 1 = priority nesting |
| irq_req | input | NUM_LINES | Request lines, sampled each rising edge |
| irq_ack | input | 1 | Processor accepts the offered interrupt |
| irq_eoi | input | 1 | Processor ends the running handler |
| irq_valid | output | 1 | An interrupt is offered |
| irq_vec | output | $clog2(NUM_LINES) | Index of the offered line |
| svc_busy | output | 1 | At least one handler is in service |
| svc_vec | output | $clog2(NUM_LINES) | Index of the handler at the top of the in-service stack |

## Verification
Two pairs of events can land in the same cycle. The first pair is an acknowledge and an end-of-handler. The bench provokes it in nested mode by putting line 2 in service, then asserting `irq_ack` and `irq_eoi` on one edge while line 1 is offered. It then expects `svc_vec`=1, and expects one further end-of-handler to leave nothing in service, which shows that line 2 was popped and not buried. The second pair is a new request on a line together with the end-of-handler of that same line. The bench drives both on one edge and expects neither an offer nor a busy handler afterwards.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    localparam int unsigned MAX_LINES = 32;

    typedef enum logic {
        SVC_SEQUENTIAL = 1'b0,
        SVC_NESTED     = 1'b1
    } svc_mode_e;

    typedef struct packed {
        logic valid;
        logic [4:0] index;
    } pick_t;

    // lowest set bit of a mask, with a found flag
    function automatic pick_t first_set(input logic [MAX_LINES-1:0] v);
        pick_t r;
        r.valid = 1'b0;
        r.index = '0;
        for (int i = MAX_LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.valid = 1'b1;
                r.index = 5'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_arrival_queue.sv
module irq_arrival_queue #(
    parameter int unsigned NUM_LINES = 8,
    localparam int unsigned IDW = $clog2(NUM_LINES),
    localparam int unsigned CW  = $clog2(NUM_LINES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] new_mask,
    input  logic                 rm_en,
    input  logic [IDW-1:0]       rm_id,
    output logic [IDW-1:0]       head_id,
    output logic [CW-1:0]        count,
    output logic [NUM_LINES-1:0] pend_mask
);

    logic [IDW-1:0]       q    [NUM_LINES];
    logic [IDW-1:0]       nq   [NUM_LINES];
    logic [CW-1:0]        cnt_n;
    logic [NUM_LINES-1:0] pend_n;
    logic [NUM_LINES-1:0] rm_hot;

    always_comb begin
        logic [CW-1:0] wr;
        rm_hot = '0;
        if (rm_en) rm_hot[rm_id] = 1'b1;
        for (int k = 0; k < NUM_LINES; k++) nq[k] = q[k];
        wr = '0;
        // keep surviving entries, compacted toward the head
        for (int k = 0; k < NUM_LINES; k++) begin
            if (CW'(k) < count && !(rm_en && q[k] == rm_id)) begin
                if (wr < CW'(NUM_LINES)) nq[IDW'(wr)] = q[k];
                wr = wr + CW'(1);
            end
        end
        // append arrivals of this edge in ascending index order
        for (int i = 0; i < NUM_LINES; i++) begin
            if (new_mask[i]) begin
                if (wr < CW'(NUM_LINES)) nq[IDW'(wr)] = IDW'(i);
                wr = wr + CW'(1);
            end
        end
        cnt_n  = wr;
        pend_n = (pend_mask & ~rm_hot) | new_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count     <= '0;
            pend_mask <= '0;
            for (int k = 0; k < NUM_LINES; k++) q[k] <= '0;
        end else begin
            count     <= cnt_n;
            pend_mask <= pend_n;
            for (int k = 0; k < NUM_LINES; k++) q[k] <= nq[k];
        end
    end

    assign head_id = q[0];

    // R8
    queue_unique_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(pend_mask) == int'(count));

    // R9
    arrival_marks_chk: assert property (@(posedge clk) disable iff (rst)
        (new_mask != '0) |=> ((pend_mask & $past(new_mask)) == $past(new_mask)));

endmodule

// File: rtl/irq_service_stack.sv
module irq_service_stack #(
    parameter int unsigned NUM_LINES = 8,
    localparam int unsigned IDW = $clog2(NUM_LINES),
    localparam int unsigned CW  = $clog2(NUM_LINES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 push_en,
    input  logic [IDW-1:0]       push_id,
    input  logic                 pop_en,
    output logic [IDW-1:0]       top_id,
    output logic [CW-1:0]        depth,
    output logic [NUM_LINES-1:0] busy_mask
);

    logic [IDW-1:0] stk [NUM_LINES];
    logic           do_pop;
    logic [CW-1:0]  base;

    assign do_pop = pop_en && (depth != '0);
    assign base   = do_pop ? depth - CW'(1) : depth;

    always_ff @(posedge clk) begin
        if (rst) begin
            depth <= '0;
            for (int k = 0; k < NUM_LINES; k++) stk[k] <= '0;
        end else begin
            if (push_en && base < CW'(NUM_LINES)) stk[IDW'(base)] <= push_id;
            depth <= base + CW'(push_en);
        end
    end

    always_comb begin
        top_id = '0;
        if (depth != '0) top_id = stk[IDW'(depth - CW'(1))];
        busy_mask = '0;
        for (int k = 0; k < NUM_LINES; k++) begin
            if (CW'(k) < depth) busy_mask[stk[k]] = 1'b1;
        end
    end

    // R6
    stack_bound_chk: assert property (@(posedge clk) disable iff (rst)
        depth <= CW'(NUM_LINES));

    // R7
    pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_en && !push_en && depth == '0) |=> depth == '0);

endmodule

// File: rtl/irq_offer_select.sv
module irq_offer_select
    import irq_nest_pkg::*;
#(
    parameter int unsigned NUM_LINES = 8,
    localparam int unsigned IDW = $clog2(NUM_LINES),
    localparam int unsigned CW  = $clog2(NUM_LINES + 1)
) (
    input  svc_mode_e            mode,
    input  logic [NUM_LINES-1:0] pend_mask,
    input  logic [IDW-1:0]       head_id,
    input  logic [CW-1:0]        count,
    input  logic                 busy,
    input  logic [IDW-1:0]       top_id,
    output logic                 offer,
    output logic [IDW-1:0]       offer_id
);

    pick_t          best;
    logic [IDW-1:0] best_id;

    assign best    = first_set(MAX_LINES'(pend_mask));
    assign best_id = IDW'(best.index);

    always_comb begin
        if (mode == SVC_NESTED) begin
            offer    = best.valid && (!busy || best_id < top_id);
            offer_id = best_id;
        end else begin
            offer    = !busy && (count != '0);
            offer_id = head_id;
        end
    end

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int unsigned NUM_LINES = 8,
    localparam int unsigned IDW = $clog2(NUM_LINES),
    localparam int unsigned CW  = $clog2(NUM_LINES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 nest_mode,
    input  logic [NUM_LINES-1:0] irq_req,
    input  logic                 irq_ack,
    input  logic                 irq_eoi,
    output logic                 irq_valid,
    output logic [IDW-1:0]       irq_vec,
    output logic                 svc_busy,
    output logic [IDW-1:0]       svc_vec
);

    logic [NUM_LINES-1:0] pend_mask;
    logic [NUM_LINES-1:0] busy_mask;
    logic [NUM_LINES-1:0] new_mask;
    logic [IDW-1:0]       head_id;
    logic [CW-1:0]        q_count;
    logic [CW-1:0]        depth;
    logic                 take;
    svc_mode_e            mode;

    assign mode     = nest_mode ? SVC_NESTED : SVC_SEQUENTIAL;
    assign new_mask = irq_req & ~pend_mask & ~busy_mask;
    assign take     = irq_ack && irq_valid;
    assign svc_busy = (depth != '0);

    irq_arrival_queue #(.NUM_LINES(NUM_LINES)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .new_mask (new_mask),
        .rm_en    (take),
        .rm_id    (irq_vec),
        .head_id  (head_id),
        .count    (q_count),
        .pend_mask(pend_mask)
    );

    irq_service_stack #(.NUM_LINES(NUM_LINES)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push_en  (take),
        .push_id  (irq_vec),
        .pop_en   (irq_eoi),
        .top_id   (svc_vec),
        .depth    (depth),
        .busy_mask(busy_mask)
    );

    irq_offer_select #(.NUM_LINES(NUM_LINES)) u_select (
        .mode     (mode),
        .pend_mask(pend_mask),
        .head_id  (head_id),
        .count    (q_count),
        .busy     (svc_busy),
        .top_id   (svc_vec),
        .offer    (irq_valid),
        .offer_id (irq_vec)
    );

    // R2
    seq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!nest_mode && svc_busy) |-> !irq_valid);

    // R4
    nest_rank_chk: assert property (@(posedge clk) disable iff (rst)
        (nest_mode && irq_valid && svc_busy) |-> irq_vec < svc_vec);

    // R6
    ack_push_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (svc_busy && svc_vec == $past(irq_vec)));

    // R6
    ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !irq_valid && !irq_eoi) |=> depth == $past(depth));

    // R8
    no_double_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_mask & busy_mask) == '0);

endmodule

// File: tb/sim_irq_nest_ctrl.sv
`timescale 1ns/1ps
module sim_irq_nest_ctrl;

    localparam int N   = 4;
    localparam int IDW = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           nest_mode = 1'b0;
    logic [N-1:0]   irq_req = '0;
    logic           irq_ack = 1'b0;
    logic           irq_eoi = 1'b0;
    logic           irq_valid;
    logic [IDW-1:0] irq_vec;
    logic           svc_busy;
    logic [IDW-1:0] svc_vec;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    irq_nest_ctrl #(.NUM_LINES(N)) u0 (
        .clk(clk), .rst(rst), .nest_mode(nest_mode), .irq_req(irq_req),
        .irq_ack(irq_ack), .irq_eoi(irq_eoi), .irq_valid(irq_valid),
        .irq_vec(irq_vec), .svc_busy(svc_busy), .svc_vec(svc_vec)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_req(input logic [N-1:0] m);
        irq_req = m;
        cyc();
        irq_req = '0;
    endtask

    task automatic do_ack();
        irq_ack = 1'b1;
        cyc();
        irq_ack = 1'b0;
    endtask

    task automatic do_eoi();
        irq_eoi = 1'b1;
        cyc();
        irq_eoi = 1'b0;
    endtask

    function automatic int lowest(input logic [N-1:0] m);
        for (int i = 0; i < N; i++) if (m[i]) return i;
        return -1;
    endfunction

    // serve one expected line: it must be offered, then it runs, then it ends
    task automatic serve(input string req, input int exp_vec, input bit others);
        chk(req, int'(irq_valid), 1);
        chk(req, int'(irq_vec), exp_vec);
        do_ack();
        chk("R6", int'(svc_busy), 1);
        chk("R6", int'(svc_vec), exp_vec);
        if (!nest_mode && others) chk("R2", int'(irq_valid), 0);
        do_eoi();
    endtask

    initial begin
        #200000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        cyc(); cyc();
        rst = 1'b0;
        cyc();
        // R1
        chk("R1", int'(irq_valid), 0);
        chk("R1", int'(svc_busy), 0);

        // R6 / R7: stray strobes with nothing offered or in service
        do_ack();
        chk("R6", int'(svc_busy), 0);
        do_eoi();
        chk("R7", int'(svc_busy), 0);
        chk("R7", int'(irq_valid), 0);

        // R4 / R9: nested sweep over every simultaneous request mask
        nest_mode = 1'b1;
        for (int m = 1; m < (1 << N); m++) begin
            logic [N-1:0] left;
            left = N'(m);
            pulse_req(left);
            while (left != '0) begin
                serve("R4", lowest(left), 1'b1);
                left[lowest(left)] = 1'b0;
            end
            chk("R4", int'(irq_valid), 0);
            chk("R7", int'(svc_busy), 0);
        end

        // R3: sequential, every arrival order, one line per edge
        nest_mode = 1'b0;
        for (int a = 0; a < N; a++)
            for (int b = 0; b < N; b++)
                for (int c = 0; c < N; c++)
                    for (int d = 0; d < N; d++) begin
                        int ord [4];
                        if (a == b || a == c || a == d || b == c || b == d || c == d) continue;
                        ord = '{a, b, c, d};
                        for (int k = 0; k < 4; k++) pulse_req(N'(1 << ord[k]));
                        for (int k = 0; k < 4; k++) serve("R3", ord[k], k < 3);
                        chk("R3", int'(irq_valid), 0);
                    end

        // R3: sequential, simultaneous arrivals in index order
        for (int m = 1; m < (1 << N); m++) begin
            logic [N-1:0] left;
            left = N'(m);
            pulse_req(left);
            while (left != '0) begin
                logic [N-1:0] rest;
                rest = left;
                rest[lowest(left)] = 1'b0;
                serve("R3", lowest(left), rest != '0);
                left = rest;
            end
        end

        // R3: a later low index waits behind an earlier pair
        pulse_req(4'b1100);
        pulse_req(4'b0001);
        serve("R3", 2, 1'b1);
        serve("R3", 3, 1'b1);
        serve("R3", 0, 1'b0);
        chk("R3", int'(irq_valid), 0);

        // R8: a waiting line asked for again is queued once
        pulse_req(4'b0010);
        pulse_req(4'b0100);
        pulse_req(4'b0010);
        serve("R8", 1, 1'b1);
        serve("R8", 2, 1'b0);
        chk("R8", int'(irq_valid), 0);

        // R4 / R5 / R7 / R8: nested preemption over every pair
        nest_mode = 1'b1;
        for (int a = 0; a < N; a++)
            for (int b = 0; b < N; b++) begin
                pulse_req(N'(1 << a));
                do_ack();
                pulse_req(N'(1 << b));
                if (b == a) begin
                    chk("R8", int'(irq_valid), 0);
                    do_eoi();
                    chk("R8", int'(irq_valid), 0);
                    chk("R8", int'(svc_busy), 0);
                end else if (b > a) begin
                    chk("R5", int'(irq_valid), 0);
                    do_eoi();
                    chk("R5", int'(svc_busy), 0);
                    serve("R5", b, 1'b0);
                end else begin
                    chk("R4", int'(irq_valid), 1);
                    chk("R4", int'(irq_vec), b);
                    do_ack();
                    chk("R6", int'(svc_vec), b);
                    do_eoi();
                    chk("R7", int'(svc_busy), 1);
                    chk("R7", int'(svc_vec), a);
                    do_eoi();
                    chk("R7", int'(svc_busy), 0);
                end
            end

        // R7: acknowledge and end-of-handler on the same edge
        pulse_req(4'b0100);
        do_ack();
        pulse_req(4'b0010);
        chk("R4", int'(irq_vec), 1);
        irq_ack = 1'b1;
        irq_eoi = 1'b1;
        cyc();
        irq_ack = 1'b0;
        irq_eoi = 1'b0;
        chk("R7", int'(svc_busy), 1);
        chk("R7", int'(svc_vec), 1);
        do_eoi();
        chk("R7", int'(svc_busy), 0);

        // R8: request on the line whose handler ends on that edge
        pulse_req(4'b1000);
        do_ack();
        irq_req = 4'b1000;
        irq_eoi = 1'b1;
        cyc();
        irq_req = '0;
        irq_eoi = 1'b0;
        chk("R8", int'(svc_busy), 0);
        chk("R8", int'(irq_valid), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule